// File: doc/BRIEF.md
# Predicate-Steered Two-Level Branch Predictor

This block predicts conditional branch directions with a per-address two-level scheme. The scheme adds one twist: every tracked branch owns two local history registers rather than one. Each entry of a direct-mapped history table stores a tag, a predicate register number and the two histories. On a lookup, the stored register number reads one bit of the predicate file vector. If that bit is 1, the "true" history is used. If it is 0, the "false" history is used. The chosen history, together with low address bits that pick one of several pattern tables, forms the index of a 2-bit saturating counter. The counter's upper bit is the prediction.

The fetch side drives an address and receives a hit flag, the predicted direction, the predicate value that steered the lookup and the pattern index that was read. When the branch resolves, the execution side hands those values back through the resolve port together with the real outcome. This lets the update train exactly the counter that made the prediction and advance only the history that formed it. A resolve for a branch that missed allocates an entry. Target addresses and speculative history repair are handled elsewhere.

All sizes are parameters. The defaults are kept small: 64 entries, 6-bit histories and 4 pattern tables. A production build sets 1024 entries, 12-bit histories and 16 pattern tables of 4096 counters.

Top module: `pspred_predictor`

## Requirements
- R1: After reset no address hits, and every pattern counter holds weakly not-taken (value 1), so the first hit on a freshly allocated branch predicts not-taken.
- R2: When the lookup misses, `lk_hit` is 0 and `lk_taken` is 0.
- R3: A resolve with `rs_hit`=0 allocates the entry selected by `rs_addr`. It writes the tag and `rs_preg`, clears both histories to zero, and makes the next lookup of that address hit.
- R4: On a hit, `lk_pval` equals `pred_file[stored register number]`. `lk_pidx` equals {`lk_addr[SEL_W-1:0]`, history}, where the history is the true history when `lk_pval` is 1 and the false history when it is 0. The history occupies the low HIST_W bits of `lk_pidx`.
- R5: On a hit, `lk_taken` is bit 1 of the counter addressed by `lk_pidx`.
- R6: A resolve with `rs_hit`=1 trains only the counter at `rs_pidx`. Taken adds one and not-taken subtracts one, saturating at 3 and at 0.
- R7: A resolve with `rs_hit`=1 whose entry still matches shifts the history chosen by `rs_pval` one place towards the MSB, with the outcome (1 taken, 0 not taken) entering bit 0. The other history is left unchanged.
- R8: The table is direct mapped. The entry index is `addr[IDX_W-1:0]` and the tag is the remaining upper bits. A different tag at the same index misses, and allocating it replaces the previous branch.
- R9: A resolve with `rs_hit`=1 whose entry no longer holds that tag still trains the counter at `rs_pidx`, but changes no history and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | ADDR_W | Branch address to predict |
| pred_file | input | NUM_PREG | Current predicate register values, bit n is register n |
| lk_hit | output | 1 | Address found in the history table |
| lk_taken | output | 1 | Predicted direction (1 taken) |
| lk_pval | output | 1 | Predicate value that steered this lookup |
| lk_pidx | output | PIX_W | Pattern index read for this lookup |
| rs_valid | input | 1 | Resolve strobe |
| rs_addr | input | ADDR_W | Address of the resolved branch |
| rs_hit | input | 1 | Hit flag returned from its lookup |
| rs_pval | input | 1 | Predicate value returned from its lookup |
| rs_pidx | input | PIX_W | Pattern index returned from its lookup |
| rs_preg | input | PREG_W | Predicate register number the branch tests |
| rs_taken | input | 1 | Actual outcome |

## Verification
The assertions assume that at most one resolve arrives per cycle. They also assume that `rs_hit`, `rs_pval` and `rs_pidx` are values the design itself produced on an earlier lookup, so a trained counter index always lies inside the pattern space. The bench honours this by looping each lookup result straight back into the following resolve. The one exception is the stale-entry scenario, which deliberately returns an older lookup's values after the entry has been replaced. Predicate file bits change only between branches, so a lookup and its check see one stable vector.

// File: rtl/pspred_pkg.sv
package pspred_pkg;

   localparam logic [1:0] CNT_WEAK_NT = 2'd1;
   localparam logic [1:0] CNT_MAX     = 2'd3;
   localparam logic [1:0] CNT_MIN     = 2'd0;

   function automatic logic [1:0] cnt_step(input logic [1:0] cur, input logic up);
      logic [1:0] nxt;
      if (up) nxt = (cur == CNT_MAX) ? cur : cur + 2'd1;
      else    nxt = (cur == CNT_MIN) ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/pspred_hist_table.sv
module pspred_hist_table #(
   parameter int ADDR_W  = 16,
   parameter int ENTRIES = 64,
   parameter int HIST_W  = 6,
   parameter int PREG_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [PREG_W-1:0] lk_preg,
   output logic [HIST_W-1:0] lk_hist_t,
   output logic [HIST_W-1:0] lk_hist_f,
   input  logic              rs_alloc,
   input  logic              rs_upd,
   input  logic [ADDR_W-1:0] rs_addr,
   input  logic [PREG_W-1:0] rs_preg,
   input  logic              rs_pval,
   input  logic              rs_taken
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = ADDR_W - IDX_W;

   logic              valid_q [ENTRIES];
   logic [TAG_W-1:0]  tag_q   [ENTRIES];
   logic [PREG_W-1:0] preg_q  [ENTRIES];
   logic [HIST_W-1:0] ht_q    [ENTRIES];
   logic [HIST_W-1:0] hf_q    [ENTRIES];

   logic [IDX_W-1:0]  li, ri;
   logic [TAG_W-1:0]  ltag, rtag;
   logic              upd_match;
   logic [HIST_W-1:0] ht_nxt, hf_nxt;

   assign li   = lk_addr[IDX_W-1:0];
   assign ltag = lk_addr[ADDR_W-1:IDX_W];
   assign ri   = rs_addr[IDX_W-1:0];
   assign rtag = rs_addr[ADDR_W-1:IDX_W];

   assign lk_hit    = valid_q[li] && (tag_q[li] == ltag);
   assign lk_preg   = preg_q[li];
   assign lk_hist_t = ht_q[li];
   assign lk_hist_f = hf_q[li];

   assign upd_match = rs_upd && valid_q[ri] && (tag_q[ri] == rtag);

   generate
      if (HIST_W == 1) begin : g_hist_one
         assign ht_nxt = rs_taken;
         assign hf_nxt = rs_taken;
      end else begin : g_hist_shift
         assign ht_nxt = {ht_q[ri][HIST_W-2:0], rs_taken};
         assign hf_nxt = {hf_q[ri][HIST_W-2:0], rs_taken};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) valid_q[e] <= 1'b0;
      end else if (rs_alloc) begin
         valid_q[ri] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rs_alloc) begin
         tag_q[ri]  <= rtag;
         preg_q[ri] <= rs_preg;
         ht_q[ri]   <= '0;
         hf_q[ri]   <= '0;
      end else if (upd_match) begin
         if (rs_pval) ht_q[ri] <= ht_nxt;
         else         hf_q[ri] <= hf_nxt;
      end
   end

   AST_FALSE_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_match && rs_pval) |=> hf_q[$past(ri)] == $past(hf_q[ri])); // R7
   AST_TRUE_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_match && !rs_pval) |=> ht_q[$past(ri)] == $past(ht_q[ri])); // R7
   AST_TRUE_HIST_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_match && rs_pval) |=> ht_q[$past(ri)][0] == $past(rs_taken)); // R7
   AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rs_alloc |=> (ht_q[$past(ri)] == '0) && (hf_q[$past(ri)] == '0)); // R3
   AST_STALE_NO_HIST: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_upd && !upd_match) |=> ht_q[$past(ri)] == $past(ht_q[ri])); // R9

endmodule

// File: rtl/pspred_pattern_table.sv
module pspred_pattern_table #(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] lk_pidx,
   output logic             lk_msb,
   input  logic             tr_en,
   input  logic [PIX_W-1:0] tr_pidx,
   input  logic             tr_taken
);
   import pspred_pkg::*;

   localparam int DEPTH = 1 << PIX_W;

   logic [1:0] cnt_q [DEPTH];

   assign lk_msb = cnt_q[lk_pidx][1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < DEPTH; c++) cnt_q[c] <= CNT_WEAK_NT;
      end else if (tr_en) begin
         cnt_q[tr_pidx] <= cnt_step(cnt_q[tr_pidx], tr_taken);
      end
   end

   AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (tr_en && tr_taken && cnt_q[tr_pidx] == CNT_MAX) |=> cnt_q[$past(tr_pidx)] == CNT_MAX); // R6
   AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tr_en && !tr_taken && cnt_q[tr_pidx] == CNT_MIN) |=> cnt_q[$past(tr_pidx)] == CNT_MIN); // R6
   AST_TRAIN_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (tr_en && tr_taken && cnt_q[tr_pidx] != CNT_MAX) |=> cnt_q[$past(tr_pidx)] != CNT_MIN); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tr_en |=> $stable(lk_msb) || !$stable(lk_pidx)); // R6

endmodule

// File: rtl/pspred_predictor.sv
module pspred_predictor #(
   parameter int ADDR_W   = 16,
   parameter int ENTRIES  = 64,
   parameter int HIST_W   = 6,
   parameter int NUM_PT   = 4,
   parameter int NUM_PREG = 64,
   localparam int SEL_W   = (NUM_PT > 1) ? $clog2(NUM_PT) : 0,
   localparam int PIX_W   = SEL_W + HIST_W,
   localparam int PREG_W  = $clog2(NUM_PREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   lk_addr,
   input  logic [NUM_PREG-1:0] pred_file,
   output logic                lk_hit,
   output logic                lk_taken,
   output logic                lk_pval,
   output logic [PIX_W-1:0]    lk_pidx,
   input  logic                rs_valid,
   input  logic [ADDR_W-1:0]   rs_addr,
   input  logic                rs_hit,
   input  logic                rs_pval,
   input  logic [PIX_W-1:0]    rs_pidx,
   input  logic [PREG_W-1:0]   rs_preg,
   input  logic                rs_taken
);
   localparam int IDX_W = $clog2(ENTRIES);

   initial begin : p_param_chk
      assert (ENTRIES >= 2 && (1 << IDX_W) == ENTRIES)
         else $error("ENTRIES must be a power of two");
      assert (NUM_PT >= 1 && (1 << SEL_W) == NUM_PT)
         else $error("NUM_PT must be a power of two");
      assert (NUM_PREG >= 2 && (1 << PREG_W) == NUM_PREG)
         else $error("NUM_PREG must be a power of two");
      assert (HIST_W >= 1 && ADDR_W > IDX_W && ADDR_W >= SEL_W)
         else $error("address or history width too small");
   end

   logic              hit_w;
   logic [PREG_W-1:0] preg_w;
   logic [HIST_W-1:0] ht_w, hf_w, hsel_w;
   logic              pval_w, msb_w;
   logic              rs_alloc, rs_upd;

   assign rs_alloc = rs_valid && !rs_hit;
   assign rs_upd   = rs_valid && rs_hit;

   pspred_hist_table #(
      .ADDR_W (ADDR_W),
      .ENTRIES(ENTRIES),
      .HIST_W (HIST_W),
      .PREG_W (PREG_W)
   ) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_addr  (lk_addr),
      .lk_hit   (hit_w),
      .lk_preg  (preg_w),
      .lk_hist_t(ht_w),
      .lk_hist_f(hf_w),
      .rs_alloc (rs_alloc),
      .rs_upd   (rs_upd),
      .rs_addr  (rs_addr),
      .rs_preg  (rs_preg),
      .rs_pval  (rs_pval),
      .rs_taken (rs_taken)
   );

   assign pval_w = pred_file[preg_w];
   assign hsel_w = pval_w ? ht_w : hf_w;

   generate
      if (SEL_W > 0) begin : g_multi_pt
         assign lk_pidx = {lk_addr[SEL_W-1:0], hsel_w};
      end else begin : g_single_pt
         assign lk_pidx = hsel_w;
      end
   endgenerate

   pspred_pattern_table #(
      .PIX_W(PIX_W)
   ) u_pat (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_pidx (lk_pidx),
      .lk_msb  (msb_w),
      .tr_en   (rs_upd),
      .tr_pidx (rs_pidx),
      .tr_taken(rs_taken)
   );

   assign lk_hit   = hit_w;
   assign lk_pval  = pval_w;
   assign lk_taken = hit_w && msb_w;

   AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> !lk_taken); // R2
   AST_ALLOC_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_hit) |=> (lk_addr != $past(rs_addr)) || lk_hit); // R3

endmodule

// File: tb/test_pspred_predictor.sv
module test_pspred_predictor;
   localparam int AW = 16, NE = 64, HW = 6, NPT = 4, NPR = 64;
   localparam int IW = 6, SW = 2, PW = SW + HW, RW = 6, TW = AW - IW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic           rst_n;
   logic [AW-1:0]  lk_addr;
   logic [NPR-1:0] pred_file;
   logic           lk_hit, lk_taken, lk_pval;
   logic [PW-1:0]  lk_pidx;
   logic           rs_valid, rs_hit, rs_pval, rs_taken;
   logic [AW-1:0]  rs_addr;
   logic [PW-1:0]  rs_pidx;
   logic [RW-1:0]  rs_preg;

   pspred_predictor #(.ADDR_W(AW), .ENTRIES(NE), .HIST_W(HW), .NUM_PT(NPT), .NUM_PREG(NPR))
   i_pspred_predictor (
      .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .pred_file(pred_file),
      .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_pval(lk_pval), .lk_pidx(lk_pidx),
      .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_hit(rs_hit), .rs_pval(rs_pval),
      .rs_pidx(rs_pidx), .rs_preg(rs_preg), .rs_taken(rs_taken)
   );

   // reference model built from the requirements
   logic          mv   [NE];
   logic [TW-1:0] mtag [NE];
   logic [RW-1:0] mpr  [NE];
   logic [HW-1:0] mht  [NE];
   logic [HW-1:0] mhf  [NE];
   logic [1:0]    mcnt [1 << PW];

   int errs = 0;
   int checks = 0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic m_hit(input logic [AW-1:0] a);
      return mv[a[IW-1:0]] && (mtag[a[IW-1:0]] == a[AW-1:IW]);
   endfunction

   task automatic m_resolve(input logic [AW-1:0] a, input logic h, input logic pv,
                            input logic [PW-1:0] pi, input logic [RW-1:0] pr, input logic tk);
      int ix = a[IW-1:0];
      if (!h) begin
         mv[ix] = 1'b1; mtag[ix] = a[AW-1:IW]; mpr[ix] = pr; mht[ix] = '0; mhf[ix] = '0;
      end else begin
         if (tk) mcnt[pi] = (mcnt[pi] == 2'd3) ? 2'd3 : mcnt[pi] + 2'd1;
         else    mcnt[pi] = (mcnt[pi] == 2'd0) ? 2'd0 : mcnt[pi] - 2'd1;
         if (m_hit(a)) begin
            if (pv) mht[ix] = {mht[ix][HW-2:0], tk};
            else    mhf[ix] = {mhf[ix][HW-2:0], tk};
         end
      end
   endtask

   task automatic drive_resolve(input logic [AW-1:0] a, input logic h, input logic pv,
                                input logic [PW-1:0] pi, input logic [RW-1:0] pr, input logic tk);
      rs_addr = a; rs_hit = h; rs_pval = pv; rs_pidx = pi; rs_preg = pr; rs_taken = tk;
      rs_valid = 1'b1;
      @(posedge clk);
      #1 rs_valid = 1'b0;
      m_resolve(a, h, pv, pi, pr, tk);
   endtask

   // lookup, compare with the model, then resolve using the returned values
   task automatic branch(input logic [AW-1:0] a, input logic [RW-1:0] pr, input logic tk, input string req);
      logic eh, ep;
      logic [PW-1:0] epi;
      int ix;
      @(negedge clk);
      lk_addr = a;
      #1;
      ix = a[IW-1:0];
      eh = m_hit(a);
      chk(req, "hit", lk_hit, eh);
      if (eh) begin
         ep  = pred_file[mpr[ix]];
         epi = {a[SW-1:0], ep ? mht[ix] : mhf[ix]};
         chk(req, "pval", lk_pval, ep);
         chk(req, "pidx", lk_pidx, epi);
         chk(req, "taken", lk_taken, mcnt[epi][1]);
      end else begin
         ep = 1'b0; epi = '0;
         chk(req, "taken on miss", lk_taken, 1'b0);
      end
      drive_resolve(a, eh, ep, epi, pr, tk);
   endtask

   task automatic t_reset();
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         lk_addr = AW'(16'h1111 * k + 16'h0003);
         #1;
         chk("R1", "hit after reset", lk_hit, 1'b0);
         chk("R2", "taken on miss", lk_taken, 1'b0);
      end
   endtask

   task automatic t_alloc();
      pred_file[5] = 1'b0;
      branch(16'h0105, 6'd5, 1'b1, "R3");
      @(negedge clk);
      lk_addr = 16'h0105;
      #1;
      chk("R3", "hit after allocation", lk_hit, 1'b1);
      chk("R4", "pidx with cleared history", lk_pidx, {2'b01, 6'b0});
      chk("R1", "weak not-taken first prediction", lk_taken, 1'b0);
   endtask

   task automatic t_predsel();
      pred_file[5] = 1'b1;
      branch(16'h0105, 6'd5, 1'b1, "R4");
      branch(16'h0105, 6'd5, 1'b0, "R7");
      branch(16'h0105, 6'd5, 1'b1, "R7");
      @(negedge clk);
      lk_addr = 16'h0105;
      #1;
      chk("R7", "true history shifted", lk_pidx, {2'b01, 6'b000101});
      pred_file[5] = 1'b0;
      #1;
      chk("R4", "pval follows predicate file", lk_pval, 1'b0);
      chk("R7", "false history untouched", lk_pidx, {2'b01, 6'b0});
   endtask

   task automatic t_saturate();
      pred_file[9] = 1'b0;
      branch(16'h0202, 6'd9, 1'b1, "R3");
      for (int k = 0; k < 12; k++) branch(16'h0202, 6'd9, 1'b1, "R6");
      @(negedge clk);
      lk_addr = 16'h0202;
      #1;
      chk("R5", "saturated counter predicts taken", lk_taken, 1'b1);
      chk("R4", "all-ones history index", lk_pidx, {2'b10, 6'b111111});
      for (int k = 0; k < 8; k++) branch(16'h0202, 6'd9, 1'b0, "R6");
      for (int k = 0; k < 3; k++) branch(16'h0202, 6'd9, k[0], "R5");
   endtask

   task automatic t_alias();
      branch(16'h4105, 6'd7, 1'b0, "R8");
      @(negedge clk);
      lk_addr = 16'h0105;
      #1;
      chk("R8", "replaced branch misses", lk_hit, 1'b0);
      lk_addr = 16'h4105;
      #1;
      chk("R8", "new tag hits", lk_hit, 1'b1);
      branch(16'h4105, 6'd7, 1'b1, "R8");
   endtask

   task automatic t_stale();
      logic [PW-1:0] old_pidx;
      logic old_pval;
      pred_file[3] = 1'b1;
      branch(16'h0333, 6'd3, 1'b1, "R3");
      @(negedge clk);
      lk_addr = 16'h0333;
      #1;
      old_pidx = lk_pidx; old_pval = lk_pval;
      branch(16'h1333, 6'd3, 1'b0, "R8");
      @(negedge clk);
      drive_resolve(16'h0333, 1'b1, old_pval, old_pidx, 6'd3, 1'b1);
      drive_resolve(16'h0333, 1'b1, old_pval, old_pidx, 6'd3, 1'b1);
      @(negedge clk);
      lk_addr = 16'h1333;
      #1;
      chk("R9", "stale resolve keeps history", lk_pidx, {2'b11, 6'b0});
      chk("R9", "stale resolve trained counter", lk_taken, 1'b1);
      chk("R9", "stale resolve keeps entry", lk_hit, 1'b1);
   endtask

   initial begin : p_watchdog
      #(200000 * 4);
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin : p_main
      for (int e = 0; e < NE; e++) begin mv[e] = 1'b0; mht[e] = '0; mhf[e] = '0; mtag[e] = '0; mpr[e] = '0; end
      for (int c = 0; c < (1 << PW); c++) mcnt[c] = 2'd1;
      rst_n = 1'b0; lk_addr = '0; pred_file = '0; rs_valid = 1'b0;
      rs_addr = '0; rs_hit = 1'b0; rs_pval = 1'b0; rs_pidx = '0; rs_preg = '0; rs_taken = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_alloc();
      t_predsel();
      t_saturate();
      t_alias();
      t_stale();
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule